// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is a host-side master that loads 14-bit codes into a serial-input current-output converter. The converter listens on three wires: an active-low select, a serial clock and a data line. Each code arrives from the surrounding logic on a valid/ready handshake. The controller captures the code into a local register as soon as it is accepted. It then plays out a 16-bit frame with the most significant bit first. The frame holds two zero padding bits followed by the 14 code bits. Finally it raises select, and the converter latches its last 14 received bits on that rising edge.

The serial clock is built from the system clock. Separate cycle counts set the high time, the low time, how long select is held low after the last clock pulse, and the minimum time select stays high between frames. Data moves only on the falling clock edge. This gives a full low phase of setup before each rising edge and a full high phase of hold after it. With the default counts and a 250 MHz system clock, each phase lasts 12 ns and the serial clock runs at about 41.7 MHz.

Top module: `dac_serial_writer`

## Requirements
- R1: After a synchronous reset, whether from idle or in the middle of a frame, `csN` is 1, `sclk` is 0, `codeReady` is 1 and `sdo` is 0.
- R2: An accepted code produces exactly 16 rising `sclk` edges while `csN` is 0. The bits sampled on those edges, first to last, form the 16-bit word whose two top bits are 0 and whose low 14 bits are the code, with bit 13 of the code sent third.
- R3: Every high phase of `sclk` lasts exactly HIGH_CYC system cycles. Every low phase inside a frame lasts exactly LOW_CYC cycles, and this includes the phase from the fall of `csN` to the first rising edge.
- R4: `sdo` changes during a frame only in the cycle where `sclk` has just fallen, so it is constant through each high phase and through the LOW_CYC cycles before each rising edge.
- R5: After the last falling `sclk` edge, `csN` stays 0 for exactly CSH_CYC cycles before it rises.
- R6: `sclk` is 0 whenever `csN` is 1.
- R7: `codeReady` is 0 from the cycle after acceptance until GAP_CYC cycles after `csN` rises, so `csN` stays high for at least GAP_CYC cycles between frames.
- R8: The code is captured on acceptance. Changes on `codeIn` and `codeValid` while a frame is in progress do not alter the frame being sent.
- R9: A code held valid in the first cycle that `codeReady` is 1 is accepted on that edge, and `csN` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| codeValid | input | 1 | A code is offered on `codeIn` |
| codeIn | input | 14 | Code to write to the converter |
| codeReady | output | 1 | The controller is idle and takes a code |
| sclk | output | 1 | Serial clock to the converter; data is sampled on the rising edge |
| sdo | output | 1 | Serial data to the converter, most significant bit first |
| csN | output | 1 | Active-low select; its rising edge latches the code |

## Verification
Codes are streamed back to back from a table that covers several patterns, each chosen to catch a different error:
- all zeros and all ones, which expose stuck data and a wrong bit count;
- alternating patterns, which catch a shift that moves by the wrong amount or a bit order that is reversed;
- a lone top bit, which separates the padding bits from the code's most significant bit;
- a lone bottom bit, which shows whether the final bit is dropped before select rises.

The same frame monitor checks every frame for phase lengths, the data edges, select hold and the gap between frames. Directed tests then check the reset state, a reset in the middle of a frame, and a frame sent while the input changes, which shows that the captured code, not the live one, is sent.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_CSHOLD,
    ST_GAP
  } dswState_e;

  typedef struct packed {
    logic load;   // capture code, drop select
    logic rise;   // raise serial clock
    logic fall;   // lower serial clock
    logic shift;  // advance to next data bit
    logic csOff;  // raise select to latch the code
  } dswStrobe_t;

endpackage

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int HIGH_CYC = 3,
  parameter int LOW_CYC  = 3,
  parameter int CSH_CYC  = 3,
  parameter int GAP_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       codeValid,
  input  logic       lastBit,
  output logic       codeReady,
  output dswStrobe_t stb
);

  localparam int MAX_AB = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int MAX_CD = (CSH_CYC > GAP_CYC) ? CSH_CYC : GAP_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] HIGH_LD = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] CSH_LD  = CNT_W'(CSH_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);

  dswState_e state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone   = (cnt == '0);
  assign codeReady = (state == ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE:   stb.load = codeValid;
      ST_LOW:    stb.rise = cntDone;
      ST_HIGH: begin
        stb.fall  = cntDone;
        stb.shift = cntDone && !lastBit;
      end
      ST_CSHOLD: stb.csOff = cntDone;
      default:   stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (codeValid) begin
            state <= ST_LOW;
            cnt   <= LOW_LD;
          end
        end
        ST_LOW: begin
          if (cntDone) begin
            state <= ST_HIGH;
            cnt   <= HIGH_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cntDone) begin
            if (lastBit) begin
              state <= ST_CSHOLD;
              cnt   <= CSH_LD;
            end else begin
              state <= ST_LOW;
              cnt   <= LOW_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CSHOLD: begin
          if (cntDone) begin
            state <= ST_GAP;
            cnt   <= GAP_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a high phase never counts beyond its programmed length
  assert_high_count_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH) |-> (cnt <= HIGH_LD));

  // R7: once a code is taken the controller is busy on the next cycle
  assert_busy_after_load_R7: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> !codeReady);

endmodule

// File: rtl/dsw_datapath.sv
module dsw_datapath
  import dsw_pkg::*;
#(
  parameter int CODE_W  = 14,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dswStrobe_t        stb,
  input  logic [CODE_W-1:0] codeIn,
  output logic              sclk,
  output logic              sdo,
  output logic              csN,
  output logic              lastBit
);

  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shiftReg;
  logic [BIT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] frameWord;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frameWord = {{PAD_W{1'b0}}, codeIn};
    end else begin : g_nopad
      assign frameWord = codeIn[FRAME_W-1:0];
    end
  endgenerate

  assign sdo     = shiftReg[FRAME_W-1];
  assign lastBit = (bitsLeft == BIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
    end else begin
      if (stb.load) begin
        shiftReg <= frameWord;
        bitsLeft <= BIT_W'(FRAME_W);
        csN      <= 1'b0;
      end else if (stb.shift) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
      if (stb.rise) sclk <= 1'b1;
      if (stb.fall) begin
        sclk     <= 1'b0;
        bitsLeft <= bitsLeft - 1'b1;
      end
      if (stb.csOff) csN <= 1'b1;
    end
  end

  // R2: a clock pulse is requested only inside a frame with bits remaining
  assert_rise_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    stb.rise |-> (!csN && bitsLeft != '0));

  // R6: the serial clock rests low while select is high
  assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    csN |-> !sclk);

  // R4: data holds through a high phase
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
  import dsw_pkg::*;
#(
  parameter int CODE_W   = 14,
  parameter int FRAME_W  = 16,
  parameter int HIGH_CYC = 3,
  parameter int LOW_CYC  = 3,
  parameter int CSH_CYC  = 3,
  parameter int GAP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] codeIn,
  output logic              codeReady,
  output logic              sclk,
  output logic              sdo,
  output logic              csN
);

  dswStrobe_t stb;
  logic lastBit;

  dsw_ctrl #(
    .HIGH_CYC(HIGH_CYC),
    .LOW_CYC (LOW_CYC),
    .CSH_CYC (CSH_CYC),
    .GAP_CYC (GAP_CYC)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .codeValid(codeValid),
    .lastBit  (lastBit),
    .codeReady(codeReady),
    .stb      (stb)
  );

  dsw_datapath #(
    .CODE_W (CODE_W),
    .FRAME_W(FRAME_W)
  ) dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .codeIn (codeIn),
    .sclk   (sclk),
    .sdo    (sdo),
    .csN    (csN),
    .lastBit(lastBit)
  );

  // R7: a ready controller has select high and the clock parked low
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    codeReady |-> (csN && !sclk));

endmodule

// File: tb/dac_serial_writer_test.sv
`timescale 1ns/1ps
module dac_serial_writer_test;

  localparam int H = 3;
  localparam int L = 3;
  localparam int C = 3;
  localparam int G = 3;
  localparam int NVEC = 6;
  // each entry: {code[13:0], expected frame word[15:0]}
  localparam logic [29:0] VECS [NVEC] = '{
    {14'h0000, 16'h0000},
    {14'h3FFF, 16'h3FFF},
    {14'h2AAA, 16'h2AAA},
    {14'h1555, 16'h1555},
    {14'h2000, 16'h2000},
    {14'h0001, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic codeValid = 1'b0;
  logic [13:0] codeIn = '0;
  logic codeReady, sclk, sdo, csN;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dac_serial_writer #(
    .HIGH_CYC(H), .LOW_CYC(L), .CSH_CYC(C), .GAP_CYC(G)
  ) uut (
    .clk(clk), .rst(rst), .codeValid(codeValid), .codeIn(codeIn),
    .codeReady(codeReady), .sclk(sclk), .sdo(sdo), .csN(csN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge with the controller idle; returns at the negedge
  // where codeReady is seen high again.
  task automatic runFrame(input logic [13:0] code, input logic [15:0] expWord,
                          input bit junk);
    int rises = 0, runLen = 1, runErr = 0, sdoErr = 0, idleErr = 0;
    int rdyErr = 0, cshLen = -1, gapLen = 0, guard = 0;
    bit sawRelease = 0, done = 0;
    logic prevSclk, prevSdo;
    logic [15:0] word = '0;
    chk(codeReady == 1'b1, "R9", "ready when offering", int'(codeReady), 1);
    codeValid = 1'b1;
    codeIn = code;
    @(negedge clk);
    chk(csN == 1'b0, "R9", "select low after accept", int'(csN), 0);
    chk(codeReady == 1'b0, "R7", "ready low after accept", int'(codeReady), 0);
    if (junk) begin
      codeIn = ~code;
      codeValid = 1'b1;
    end else begin
      codeValid = 1'b0;
    end
    prevSclk = sclk;
    prevSdo = sdo;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (csN && sclk) idleErr++;
      if (!csN) begin
        if (codeReady) rdyErr++;
        if (sclk != prevSclk) begin
          if (prevSclk ? (runLen != H) : (runLen != L)) runErr++;
          if (sclk) begin
            rises++;
            word = {word[14:0], sdo};
          end
          runLen = 1;
        end else begin
          runLen++;
        end
        if (sdo != prevSdo && !(prevSclk && !sclk)) sdoErr++;
      end else begin
        if (!sawRelease) begin
          sawRelease = 1;
          cshLen = runLen;
          codeValid = 1'b0;
        end
        if (codeReady) done = 1;
        else gapLen++;
      end
      prevSclk = sclk;
      prevSdo = sdo;
    end
    chk(done, "R7", "frame completed", int'(done), 1);
    chk(rises == 16, "R2", "rising edge count", rises, 16);
    chk(word == expWord, junk ? "R8" : "R2", "frame word", int'(word), int'(expWord));
    chk(runErr == 0, "R3", "phase length errors", runErr, 0);
    chk(sdoErr == 0, "R4", "data change off falling edge", sdoErr, 0);
    chk(cshLen == C, "R5", "select hold after last fall", cshLen, C);
    chk(gapLen == G, "R7", "high gap before ready", gapLen, G);
    chk(idleErr == 0, "R6", "clock high with select high", idleErr, 0);
    chk(rdyErr == 0, "R7", "ready during frame", rdyErr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csN == 1'b1, "R1", "select after reset", int'(csN), 1);
    chk(sclk == 1'b0, "R1", "clock after reset", int'(sclk), 0);
    chk(codeReady == 1'b1, "R1", "ready after reset", int'(codeReady), 1);
    chk(sdo == 1'b0, "R1", "data after reset", int'(sdo), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk, frames back to back (R2..R7, R9)
    for (int i = 0; i < NVEC; i++) begin
      runFrame(VECS[i][29:16], VECS[i][15:0], 1'b0);
    end

    // R8: live input changes during a frame are ignored
    runFrame(14'h1234, 16'h1234, 1'b1);
    codeIn = '0;

    // R1: reset in the middle of a frame
    codeValid = 1'b1;
    codeIn = 14'h3C3C;
    @(negedge clk);
    codeValid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "select after mid-frame reset", int'(csN), 1);
    chk(sclk == 1'b0, "R1", "clock after mid-frame reset", int'(sclk), 0);
    chk(codeReady == 1'b1, "R1", "ready after mid-frame reset", int'(codeReady), 1);
    chk(sdo == 1'b0, "R1", "data after mid-frame reset", int'(sdo), 0);
    rst = 1'b0;
    @(negedge clk);
    runFrame(14'h0F0F, 16'h0F0F, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule